// File: doc/BRIEF.md
# Hamming (7,4) Single-Error-Correcting Codec with Optional Double-Error Detection

The block holds two independent one-stage pipelines that share a clock and a synchronous active-high reset. The encode path takes a 4-bit data word and produces a 7-bit even-parity Hamming codeword. Codeword positions are numbered from 1 at the least significant end. Parity bits sit at the power-of-two positions, and the data bits fill positions 3, 5, 6 and 7. The decode path takes a received word and rechecks each parity group. The failing checks form a 3-bit syndrome, and that syndrome, read as a binary number, is the position of the flipped bit. The decoder inverts that bit and returns the repaired data together with status flags.

With the `SECDED` parameter set, an eighth overall-parity bit covers the seven positions. The decoder uses it to tell a single error, which it corrects, from a double error, which it reports and leaves alone. With the parameter cleared, bit 7 of the encoder output is driven low and the decoder ignores bit 7 of its input.

Top module: `hamc74_codec`

## Requirements
- R1: Codeword bit i of `enc_code_o[6:0]` holds position i+1. Data bit 0 goes to position 3, bit 1 to position 5, bit 2 to position 6 and bit 3 to position 7. The parity at position 1 makes positions {1,3,5,7} even, position 2 makes {2,3,6,7} even, and position 4 makes {4,5,6,7} even. Data 1101 encodes to 1100110.
- R2: A received word with a zero syndrome and good overall parity gives the stored data bits unchanged, with `dec_fixed_o` and `dec_double_o` low and `dec_pos_o` equal to 0.
- R3: A single flipped data position (3, 5, 6 or 7) is repaired. `dec_fixed_o` is high, `dec_pos_o` equals that position and `dec_double_o` is low. A received 1110110 gives position 5 and data 1101.
- R4: A single flipped parity position (1, 2 or 4) is reported and handled like a data error, and the data is unaffected. A received 1100111 gives position 1 and data 1101.
- R5: With SECDED set, `enc_code_o[7]` makes all eight output bits even.
- R6: With SECDED set, a non-zero syndrome with good overall parity raises `dec_double_o`. In that case `dec_fixed_o` is low, `dec_pos_o` is 0, and the data bits are output exactly as received.
- R7: With SECDED set, a zero syndrome with failing overall parity means only bit 7 flipped. `dec_fixed_o` is high, `dec_pos_o` is 0 and the data is unchanged.
- R8: Each output valid equals its input valid one clock earlier. `dec_fixed_o` and `dec_double_o` are low whenever `dec_valid_o` is low. The two paths run independently in the same cycle.
- R9: While `rst` is high at a clock edge, both output valids and both decoder flags are cleared, whatever the inputs are.
- R10: With SECDED cleared, `enc_code_o[7]` is 0. `dec_code_i[7]` has no effect on the decoder, and `dec_double_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | 4 | Data word to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 8 | Codeword, bit 7 overall parity |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | 8 | Received word, bit 7 overall parity |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 4 | Repaired (or raw, on double error) data |
| dec_fixed_o | output | 1 | A single error was found and corrected |
| dec_double_o | output | 1 | An uncorrectable double error was found |
| dec_pos_o | output | 3 | Position of the corrected bit, 0 if none |

## Verification
An encode and a decode can be accepted on the same clock edge, and their results leave the block together one cycle later. The bench raises both valids on one edge. It sends a fresh data word into the encoder while the decoder receives a corrupted copy of a different codeword. One cycle later it judges the codeword against its own parity model, and the corrected data and position against the bit it flipped. Back-to-back decodes with alternating clean and faulty words confirm that a flag raised in one cycle does not carry into the next result.

// File: rtl/hamc74_pkg.sv
package hamc74_pkg;

    localparam int DATA_W = 4;
    localparam int PAR_W  = 3;
    localparam int CW_W   = DATA_W + PAR_W;
    localparam int XW     = CW_W + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   code_t;
    typedef logic [XW-1:0]     xcode_t;
    typedef logic [PAR_W-1:0]  syn_t;

    typedef struct packed {
        data_t data;
        logic  fixed;
        logic  dbl;
        syn_t  pos;
    } dec_res_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // scatter data bits, ascending, into non-power-of-two positions
    function automatic code_t ham_place(input data_t d);
        code_t c;
        int    k;
        c = '0;
        k = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                c[p-1] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    function automatic data_t ham_extract(input code_t c);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = c[p-1];
                k++;
            end
        end
        return d;
    endfunction

    function automatic syn_t ham_syndrome(input code_t c);
        syn_t s;
        s = '0;
        for (int j = 0; j < PAR_W; j++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (p[j]) s[j] = s[j] ^ c[p-1];
            end
        end
        return s;
    endfunction

    function automatic code_t ham_encode(input data_t d);
        code_t c;
        syn_t  s;
        c = ham_place(d);
        s = ham_syndrome(c);
        for (int j = 0; j < PAR_W; j++) begin
            c[(1 << j) - 1] = s[j];
        end
        return c;
    endfunction

endpackage

// File: rtl/hamc74_enc.sv
module hamc74_enc
    import hamc74_pkg::*;
#(
    parameter bit SECDED = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  data_t  in_data,
    output logic   out_valid,
    output xcode_t out_code
);

    code_t cw;
    logic  ovr;

    always_comb cw = ham_encode(in_data);

    generate
        if (SECDED) begin : g_ovr
            assign ovr = ^cw;
        end else begin : g_no_ovr
            assign ovr = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_code <= {ovr, cw};
        end
    end

endmodule

// File: rtl/hamc74_dec.sv
module hamc74_dec
    import hamc74_pkg::*;
#(
    parameter bit SECDED = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  xcode_t   in_code,
    output logic     out_valid,
    output dec_res_t out_res
);

    code_t    cw;
    syn_t     syn;
    code_t    mask;
    dec_res_t res;

    always_comb begin
        cw   = in_code[CW_W-1:0];
        syn  = ham_syndrome(cw);
        mask = (syn == '0) ? '0 : (code_t'(1) << (syn - syn_t'(1)));
    end

    generate
        if (SECDED) begin : g_secded
            logic ovf;
            assign ovf = ^in_code;
            always_comb begin
                res      = '0;
                res.data = ham_extract(cw);
                if (syn != '0 && !ovf) begin
                    res.dbl = 1'b1;
                end else if (syn != '0) begin
                    res.data  = ham_extract(cw ^ mask);
                    res.fixed = 1'b1;
                    res.pos   = syn;
                end else if (ovf) begin
                    res.fixed = 1'b1;
                end
            end
        end else begin : g_sec
            logic unused_top;
            assign unused_top = in_code[XW-1];
            always_comb begin
                res      = '0;
                res.data = ham_extract(cw ^ mask);
                if (syn != '0) begin
                    res.fixed = 1'b1;
                    res.pos   = syn;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= res;
            end else begin
                out_res.fixed <= 1'b0;
                out_res.dbl   <= 1'b0;
                out_res.pos   <= '0;
            end
        end
    end

endmodule

// File: rtl/hamc74_codec.sv
module hamc74_codec
    import hamc74_pkg::*;
#(
    parameter bit SECDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [XW-1:0]     enc_code_o,
    input  logic              dec_valid_i,
    input  logic [XW-1:0]     dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_fixed_o,
    output logic              dec_double_o,
    output logic [PAR_W-1:0]  dec_pos_o
);

    dec_res_t dres;

    hamc74_enc #(.SECDED(SECDED)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (enc_valid_i),
        .in_data   (enc_data_i),
        .out_valid (enc_valid_o),
        .out_code  (enc_code_o)
    );

    hamc74_dec #(.SECDED(SECDED)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_valid_i),
        .in_code   (dec_code_i),
        .out_valid (dec_valid_o),
        .out_res   (dres)
    );

    assign dec_data_o   = dres.data;
    assign dec_fixed_o  = dres.fixed;
    assign dec_double_o = dres.dbl;
    assign dec_pos_o    = dres.pos;

endmodule

// File: rtl/hamc74_chk.sv
module hamc74_chk #(
    parameter bit SECDED = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       enc_valid_i,
    input logic       enc_valid_o,
    input logic [7:0] enc_code_o,
    input logic       dec_valid_i,
    input logic       dec_valid_o,
    input logic       dec_fixed_o,
    input logic       dec_double_o,
    input logic [2:0] dec_pos_o
);

    // R1: each parity group of an emitted codeword is even
    a_r1_grp_one: assert property (@(posedge clk) disable iff (rst)
        enc_valid_o |-> !(enc_code_o[0] ^ enc_code_o[2] ^ enc_code_o[4] ^ enc_code_o[6]));
    a_r1_grp_two: assert property (@(posedge clk) disable iff (rst)
        enc_valid_o |-> !(enc_code_o[1] ^ enc_code_o[2] ^ enc_code_o[5] ^ enc_code_o[6]));
    a_r1_grp_four: assert property (@(posedge clk) disable iff (rst)
        enc_valid_o |-> !(enc_code_o[3] ^ enc_code_o[4] ^ enc_code_o[5] ^ enc_code_o[6]));

    // R5: overall parity over all eight bits
    a_r5_overall_even: assert property (@(posedge clk) disable iff (rst)
        (SECDED && enc_valid_o) |-> (^enc_code_o == 1'b0));

    // R6: double error never reports a position and never claims a fix
    a_r6_double_clean: assert property (@(posedge clk) disable iff (rst)
        dec_double_o |-> (dec_pos_o == 3'd0 && !dec_fixed_o));

    // R10: no double flag without the overall bit
    a_r10_no_double: assert property (@(posedge clk) disable iff (rst)
        !SECDED |-> !dec_double_o);

    // R8: one-cycle valid latency on both paths
    a_r8_enc_lat: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o);
    a_r8_enc_idle: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> !enc_valid_o);
    a_r8_dec_lat: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> dec_valid_o);
    a_r8_dec_idle: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> !dec_valid_o);
    a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        (dec_fixed_o || dec_double_o) |-> dec_valid_o);

    // R2: a position is only reported with a fix
    a_r2_pos_needs_fix: assert property (@(posedge clk) disable iff (rst)
        (dec_pos_o != 3'd0) |-> dec_fixed_o);

endmodule

bind hamc74_codec hamc74_chk #(.SECDED(SECDED)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enc_valid_i  (enc_valid_i),
    .enc_valid_o  (enc_valid_o),
    .enc_code_o   (enc_code_o),
    .dec_valid_i  (dec_valid_i),
    .dec_valid_o  (dec_valid_o),
    .dec_fixed_o  (dec_fixed_o),
    .dec_double_o (dec_double_o),
    .dec_pos_o    (dec_pos_o)
);

// File: tb/hamc74_codec_test.sv
module hamc74_codec_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_valid_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       dec_valid_i = 1'b0;
    logic [7:0] dec_code_i = '0;

    logic       enc_valid_o, dec_valid_o, dec_fixed_o, dec_double_o;
    logic [7:0] enc_code_o;
    logic [3:0] dec_data_o;
    logic [2:0] dec_pos_o;

    logic       s_enc_valid_o, s_dec_valid_o, s_dec_fixed_o, s_dec_double_o;
    logic [7:0] s_enc_code_o;
    logic [3:0] s_dec_data_o;
    logic [2:0] s_dec_pos_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hamc74_codec #(.SECDED(1'b1)) uut (
        .clk(clk), .rst(rst),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_fixed_o(dec_fixed_o), .dec_double_o(dec_double_o),
        .dec_pos_o(dec_pos_o)
    );

    hamc74_codec #(.SECDED(1'b0)) uut_sec (
        .clk(clk), .rst(rst),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(s_enc_valid_o), .enc_code_o(s_enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(s_dec_valid_o), .dec_data_o(s_dec_data_o),
        .dec_fixed_o(s_dec_fixed_o), .dec_double_o(s_dec_double_o),
        .dec_pos_o(s_dec_pos_o)
    );

    // independent model: groups written out by position
    function automatic logic [7:0] model_enc(input logic [3:0] d);
        logic p1, p2, p4;
        logic [6:0] cw;
        p1 = d[0] ^ d[1] ^ d[3];
        p2 = d[0] ^ d[2] ^ d[3];
        p4 = d[1] ^ d[2] ^ d[3];
        cw = {d[3], d[2], d[1], p4, d[0], p2, p1};
        return {^cw, cw};
    endfunction

    function automatic logic [3:0] raw_data(input logic [7:0] c);
        return {c[6], c[5], c[4], c[2]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enc_one(input logic [3:0] d);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        @(negedge clk);
        enc_valid_i = 1'b0;
    endtask

    task automatic dec_one(input logic [7:0] c);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_code_i  = c;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        enc_valid_i = 1'b1;
        dec_valid_i = 1'b1;
        dec_code_i  = 8'h01;
        repeat (3) @(negedge clk);
        chk("R9 enc valid in reset", enc_valid_o, 0);
        chk("R9 dec valid in reset", dec_valid_o, 0);
        chk("R9 fixed in reset", dec_fixed_o, 0);
        chk("R9 double in reset", dec_double_o, 0);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_examples;
        enc_one(4'b1101);
        chk("R1 example code", enc_code_o[6:0], 7'b1100110);
        chk("R8 enc valid", enc_valid_o, 1);
        dec_one({1'b0, 7'b1100110});
        chk("R2 clean data", dec_data_o, 4'b1101);
        chk("R2 clean fixed", dec_fixed_o, 0);
        chk("R2 clean pos", dec_pos_o, 0);
        dec_one({1'b0, 7'b1110110});
        chk("R3 example data", dec_data_o, 4'b1101);
        chk("R3 example pos", dec_pos_o, 5);
        chk("R3 example fixed", dec_fixed_o, 1);
        dec_one({1'b0, 7'b1100111});
        chk("R4 example data", dec_data_o, 4'b1101);
        chk("R4 example pos", dec_pos_o, 1);
        chk("R4 example double", dec_double_o, 0);
    endtask

    task automatic t_sweep;
        for (int d = 0; d < 16; d++) begin
            logic [7:0] cw;
            cw = model_enc(4'(d));
            enc_one(4'(d));
            chk("R1 encode", enc_code_o[6:0], cw[6:0]);
            chk("R5 overall", enc_code_o[7], cw[7]);
            for (int b = 0; b < 7; b++) begin
                dec_one(cw ^ (8'd1 << b));
                if (b == 0 || b == 1 || b == 3) begin
                    chk("R4 parity err data", dec_data_o, d);
                    chk("R4 parity err pos", dec_pos_o, b + 1);
                    chk("R4 parity err fixed", dec_fixed_o, 1);
                end else begin
                    chk("R3 data err data", dec_data_o, d);
                    chk("R3 data err pos", dec_pos_o, b + 1);
                    chk("R3 data err fixed", dec_fixed_o, 1);
                end
                chk("R3 no double", dec_double_o, 0);
            end
            dec_one(cw ^ 8'h80);
            chk("R7 overall-only data", dec_data_o, d);
            chk("R7 overall-only fixed", dec_fixed_o, 1);
            chk("R7 overall-only pos", dec_pos_o, 0);
        end
    endtask

    task automatic t_double;
        for (int d = 0; d < 16; d++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = i + 1; j < 8; j++) begin
                    logic [7:0] bad;
                    bad = model_enc(4'(d)) ^ (8'd1 << i) ^ (8'd1 << j);
                    dec_one(bad);
                    chk("R6 double flag", dec_double_o, 1);
                    chk("R6 double fixed", dec_fixed_o, 0);
                    chk("R6 double pos", dec_pos_o, 0);
                    chk("R6 raw data", dec_data_o, raw_data(bad));
                end
            end
        end
    endtask

    task automatic t_latency;
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_code_i  = model_enc(4'h9) ^ 8'h04;
        chk("R8 dec valid before edge", dec_valid_o, 0);
        @(negedge clk);
        dec_valid_i = 1'b0;
        chk("R8 dec valid after edge", dec_valid_o, 1);
        chk("R8 fixed with valid", dec_fixed_o, 1);
        @(negedge clk);
        chk("R8 dec valid drops", dec_valid_o, 0);
        chk("R8 fixed drops", dec_fixed_o, 0);
        chk("R8 pos drops", dec_pos_o, 0);
    endtask

    task automatic t_concurrent;
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = 4'hA;
        dec_valid_i = 1'b1;
        dec_code_i  = model_enc(4'h3) ^ 8'h20;
        @(negedge clk);
        chk("R8 both enc code", enc_code_o, model_enc(4'hA));
        chk("R8 both dec data", dec_data_o, 4'h3);
        chk("R8 both dec pos", dec_pos_o, 6);
        enc_valid_i = 1'b0;
        dec_code_i  = model_enc(4'h7);
        @(negedge clk);
        chk("R8 next clean fixed", dec_fixed_o, 0);
        chk("R8 next clean data", dec_data_o, 4'h7);
        chk("R8 enc idle", enc_valid_o, 0);
        dec_code_i  = model_enc(4'hE) ^ 8'h01 ^ 8'h40;
        @(negedge clk);
        chk("R8 next double", dec_double_o, 1);
        dec_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_plain;
        enc_one(4'h1);
        chk("R10 enc top bit", s_enc_code_o[7], 0);
        chk("R10 enc code", s_enc_code_o[6:0], model_enc(4'h1) & 8'h7f);
        dec_one((model_enc(4'h6) & 8'h7f) | 8'h80);
        chk("R10 top ignored fixed", s_dec_fixed_o, 0);
        chk("R10 top ignored data", s_dec_data_o, 4'h6);
        dec_one(((model_enc(4'hC) & 8'h7f) | 8'h80) ^ 8'h10);
        chk("R10 single fixed", s_dec_data_o, 4'hC);
        chk("R10 single pos", s_dec_pos_o, 5);
        chk("R10 no double", s_dec_double_o, 0);
    endtask

    task automatic t_reset_midstream;
        @(negedge clk);
        enc_valid_i = 1'b1;
        dec_valid_i = 1'b1;
        dec_code_i  = model_enc(4'h5) ^ 8'h02;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 enc valid cleared", enc_valid_o, 0);
        chk("R9 dec valid cleared", dec_valid_o, 0);
        chk("R9 fixed cleared", dec_fixed_o, 0);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_examples;
        t_sweep;
        t_double;
        t_latency;
        t_concurrent;
        t_plain;
        t_reset_midstream;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule